// File: doc/BRIEF.md
# Static RAM Bus Access Controller

This block turns single requests from an internal port into access cycles on an external asynchronous static RAM bus. Everything runs on one clock. A request carries an address, a read/write flag, an access size and write data. The controller then runs a short fixed sequence of bus phases: a start phase T1, an optional run of wait phases, and a final strobe phase T2. During that sequence it drives chip select, the read strobe, per-byte write enables, a direction line, a one-cycle start marker, the address and, on writes, the data bus.

Reads always sample the whole data bus, whatever size was requested. The address bus still shows the exact start address, including its low bits. A wait-state count, sampled when a request is taken, stretches each access by whole cycles. The result comes back as a one-cycle done pulse. On reads the pulse is accompanied by the captured word. A single acknowledge output, with selectable polarity, marks the span of every access for an external transfer engine.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, `req_ready` is 1, `bus_cs_n`, `bus_rd_n` and `bus_start_n` are 1, and all bits of `bus_we_n` are 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. With zero wait states the bus access takes exactly two cycles (T1, then T2), and `rsp_done` is 1 for exactly one cycle, the cycle right after T2.
- R3: `bus_start_n` is 0 for exactly one cycle per access, in T1, and is 1 in every other phase.
- R4: `bus_cs_n` is 0 from T1 through T2, including any wait phases. `bus_rnw` is 1 for a read and 0 for a write over that same span, and is 1 when idle.
- R5: A wait count of N, sampled from `wait_cfg` when the request is taken, inserts exactly N cycles between T1 and T2 and delays `rsp_done` by N cycles. The read strobe or the write enables are inactive in T1 and active in every wait cycle and in T2.
- R6: Size encoding on `req_size` is 0 = byte, 1 = 16-bit half, 2 or 3 = 32-bit word. Lanes are little-endian: lane k is data bits 8k+7..8k and maps to `bus_we_n[k]`. A write drives low only the lanes the access covers:
  - a byte access drives lane addr[1:0];
  - a half access drives lanes 2·addr[1] and 2·addr[1]+1;
  - a word access drives all four lanes.
- R7: On a write, `bus_data` carries `req_wdata` unchanged from T1 through T2. On a read the controller does not drive the bus, so the memory's value reaches it.
- R8: On a read, `bus_rd_n` is 0 while all `bus_we_n` bits stay 1. All 32 bits of `bus_data` are captured on the edge that ends T2 and appear on `rsp_rdata` with `rsp_done`, for every size.
- R9: `bus_addr` equals the full requested address, low bits included, in every cycle of the access.
- R10: `bus_ack` is active for every cycle from T1 through T2 and inactive otherwise. When `ack_low` is 1 the active level is 0; otherwise it is 1.
- R11: `req_valid` has no effect while an access is in progress: no new start is issued, and the address of the running access does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte start address |
| req_wdata | input | DATA_W | Write data, already on its lanes |
| wait_cfg | input | WAIT_W | Wait states for the next access |
| ack_low | input | 1 | 1 = acknowledge is active low |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read word |
| bus_addr | output | ADDR_W | External address bus |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | DATA_W/8 | Per-lane write enables, active low |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_start_n | output | 1 | Access start marker, active low |
| bus_ack | output | 1 | Transfer acknowledge, polarity per ack_low |
| bus_data | inout | DATA_W | Bidirectional data bus |

## Verification
The sweep covers every wait count from 0 to 3, every size and every low-address pair, for both reads and writes. A wrong lane decode shows up as a stray or missing write enable. An off-by-one in the wait counter moves the strobe or the done pulse by a cycle. A read that masked its data by size would lose the memory's bytes outside the requested lane. A request raised in the middle of an access must leave the running address alone and must not cause a second start; a controller that latched it would show the intruding address or an extra chip-select cycle. The acknowledge polarity is flipped between accesses, so a fixed-level output would be caught.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  // Bus phase of the access sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_TW   = 2'd2,
    PH_T2   = 2'd3
  } phase_e;

  // Requested access width
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } acc_size_e;

endpackage

// File: rtl/sram_seq.sv
module sram_seq
  import sram_bus_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              accept,
  output phase_e            phase
);

  phase_e            ph_q, ph_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;

  assign accept = req_valid && (ph_q == PH_IDLE);
  assign phase  = ph_q;

  // next-state process
  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          ph_d  = PH_T1;
          cnt_d = wait_cfg;
        end
      end
      PH_T1: begin
        ph_d = (cnt_q == '0) ? PH_T2 : PH_TW;
      end
      PH_TW: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == WAIT_W'(1)) ph_d = PH_T2;
      end
      PH_T2: begin
        ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: a taken request always opens with T1
  a_r2_t1_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (ph_q == PH_T1));

  // R5: a wait phase only exists while wait cycles remain
  a_r5_wait_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TW) |-> (cnt_q != '0));

  // R2: T2 is always followed by idle
  a_r2_t2_single: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_T2) |=> (ph_q == PH_IDLE));

endmodule

// File: rtl/sram_lane_dec.sv
module sram_lane_dec
  import sram_bus_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]               size,
  input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
  output logic [DATA_W/8-1:0]      lane_en
);

  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);

  acc_size_e sz;
  assign sz = acc_size_e'(size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [LB-1:0] IDX = LB'(k);
    always_comb begin
      case (sz)
        SZ_BYTE: lane_en[k] = (IDX == addr_lo);
        SZ_HALF: lane_en[k] = (IDX[LB-1:1] == addr_lo[LB-1:1]);
        default: lane_en[k] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase,
  input  logic                write_q,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [DATA_W-1:0]   wdata_q,
  input  logic [DATA_W/8-1:0] lane_en,
  input  logic                ack_low,
  input  logic [DATA_W-1:0]   bus_din,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_cs_n,
  output logic                bus_rd_n,
  output logic [DATA_W/8-1:0] bus_we_n,
  output logic                bus_rnw,
  output logic                bus_start_n,
  output logic                bus_ack,
  output logic                drv_oe,
  output logic [DATA_W-1:0]   drv_data,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata
);

  localparam int LANES = DATA_W / 8;

  logic active, strobe, last;
  logic              done_d, done_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              cap_en;

  assign active = (phase != PH_IDLE);
  assign strobe = (phase == PH_TW) || (phase == PH_T2);
  assign last   = (phase == PH_T2);

  always_comb begin
    bus_cs_n    = !active;
    bus_start_n = !(phase == PH_T1);
    bus_rnw     = active ? !write_q : 1'b1;
    bus_rd_n    = !(strobe && !write_q);
    bus_we_n    = (strobe && write_q) ? ~lane_en : {LANES{1'b1}};
    bus_addr    = active ? addr_q : '0;
    bus_ack     = active ^ ack_low;
    drv_oe      = active && write_q;
    drv_data    = wdata_q;
  end

  // response next-state
  assign cap_en = last && !write_q;
  always_comb begin
    done_d  = last;
    rdata_d = rdata_q;
    if (cap_en) rdata_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

  // R3: start marker never lasts two cycles
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_n |=> bus_start_n);

  // R4: no strobe outside chip select
  a_r4_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !(&bus_we_n)) |-> !bus_cs_n);

  // R8: read strobe and write enables are exclusive
  a_r8_rd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (&bus_we_n) && bus_rnw);

  // R2: done pulse is a single cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R6: the write enables never cover three lanes
  a_r6_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
    !(&bus_we_n) |-> ($countones(~bus_we_n) != 3) && !bus_rnw);

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [WAIT_W-1:0]   wait_cfg,
  input  logic                ack_low,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_cs_n,
  output logic                bus_rd_n,
  output logic [DATA_W/8-1:0] bus_we_n,
  output logic                bus_rnw,
  output logic                bus_start_n,
  output logic                bus_ack,
  inout  wire  [DATA_W-1:0]   bus_data
);

  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  logic   accept;
  phase_e phase;

  sram_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (arst_n),
    .req_valid (req_valid),
    .wait_cfg  (wait_cfg),
    .accept    (accept),
    .phase     (phase)
  );

  assign req_ready = (phase == PH_IDLE);

  // request holding registers, loaded on accept
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [1:0]        size_q, size_d;
  logic              write_q, write_d;

  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    size_d  = size_q;
    write_d = write_q;
    if (accept) begin
      addr_d  = req_addr;
      wdata_d = req_wdata;
      size_d  = req_size;
      write_d = req_write;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      size_q  <= size_d;
      write_q <= write_d;
    end
  end

  logic [LANES-1:0] lane_en;

  sram_lane_dec #(.DATA_W(DATA_W)) u_lanes (
    .size    (size_q),
    .addr_lo (addr_q[LB-1:0]),
    .lane_en (lane_en)
  );

  logic              drv_oe;
  logic [DATA_W-1:0] drv_data;

  sram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (arst_n),
    .phase       (phase),
    .write_q     (write_q),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .lane_en     (lane_en),
    .ack_low     (ack_low),
    .bus_din     (bus_data),
    .bus_addr    (bus_addr),
    .bus_cs_n    (bus_cs_n),
    .bus_rd_n    (bus_rd_n),
    .bus_we_n    (bus_we_n),
    .bus_rnw     (bus_rnw),
    .bus_start_n (bus_start_n),
    .bus_ack     (bus_ack),
    .drv_oe      (drv_oe),
    .drv_data    (drv_data),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata)
  );

  assign bus_data = drv_oe ? drv_data : {DATA_W{1'bz}};

  // R1: idle means a quiet bus
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    req_ready |-> bus_cs_n && bus_rd_n && (&bus_we_n) && bus_start_n);

  // R11: a busy cycle is never followed by a fresh start
  a_r11_no_start_when_busy: assert property (@(posedge clk) disable iff (!arst_n)
    !req_ready |=> bus_start_n);

  // R9: the address holds steady across an access
  a_r9_addr_steady: assert property (@(posedge clk) disable iff (!arst_n)
    (!bus_cs_n && bus_start_n) |-> $stable(bus_addr));

endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;

  localparam int AW = 26;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write, ack_low;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [WW-1:0] wait_cfg;
  logic          req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_rnw, bus_start_n, bus_ack;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_we_n;
  wire  [DW-1:0] bus_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [31:0] rd_pat(input logic [AW-1:0] a);
    return {8'hC3 ^ a[7:0], a[7:0], ~a[7:0], 8'h3C ^ a[9:2]};
  endfunction

  function automatic logic [31:0] wr_pat(input logic [AW-1:0] a);
    return {a[7:0], ~a[7:0], 8'h96 ^ a[7:0], a[7:0] + 8'd17};
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 4'b0001 << lo;
    if (sz == 2'd1) return 4'b0011 << (lo[1] * 2);
    return 4'b1111;
  endfunction

  // memory model: drives the bus while the read strobe is active
  assign bus_data = bus_rd_n ? {DW{1'bz}} : rd_pat(bus_addr);

  sram_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .wait_cfg(wait_cfg), .ack_low(ack_low),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_rnw(bus_rnw), .bus_start_n(bus_start_n),
    .bus_ack(bus_ack), .bus_data(bus_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic access(input bit w, input logic [1:0] sz, input logic [AW-1:0] a,
                        input int wc, input bit al, input bit intrude);
    logic [31:0] wd;
    logic [3:0]  we_exp;
    wd     = wr_pat(a);
    we_exp = ~lane_mask(sz, a[1:0]);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a;
    req_wdata = wd; wait_cfg = WW'(wc); ack_low = al;
    @(negedge clk);  // T1
    req_valid = 1'b0;
    if (intrude) begin
      req_valid = 1'b1; req_addr = a ^ 26'h155; req_write = ~w;
    end
    chk(bus_start_n == 1'b0, "R3 start in T1", {31'd0, bus_start_n}, 32'd0);
    chk(bus_cs_n == 1'b0, "R4 cs in T1", {31'd0, bus_cs_n}, 32'd0);
    chk(bus_rnw == !w, "R4 rnw in T1", {31'd0, bus_rnw}, {31'd0, !w});
    chk(bus_rd_n && bus_we_n == 4'hF, "R5 no strobe in T1", {27'd0, bus_rd_n, bus_we_n}, 32'h1F);
    chk(bus_addr == a, "R9 addr in T1", 32'(bus_addr), 32'(a));
    chk(bus_ack == !al, "R10 ack active in T1", {31'd0, bus_ack}, {31'd0, !al});
    chk(req_ready == 1'b0, "R11 busy in T1", {31'd0, req_ready}, 32'd0);
    if (w) chk(bus_data == wd, "R7 wdata in T1", bus_data, wd);
    for (int n = 0; n < wc; n++) begin
      @(negedge clk);
      chk(bus_start_n == 1'b1, "R3 start off in wait", {31'd0, bus_start_n}, 32'd1);
      chk(bus_cs_n == 1'b0, "R4 cs in wait", {31'd0, bus_cs_n}, 32'd0);
      chk(rsp_done == 1'b0, "R5 done held off in wait", {31'd0, rsp_done}, 32'd0);
      chk(bus_addr == a, "R9 addr in wait", 32'(bus_addr), 32'(a));
      if (w) chk(bus_we_n == we_exp && bus_rd_n, "R5 write strobe in wait", {28'd0, bus_we_n}, {28'd0, we_exp});
      else   chk(bus_rd_n == 1'b0, "R5 read strobe in wait", {31'd0, bus_rd_n}, 32'd0);
    end
    @(negedge clk);  // T2
    if (intrude) req_valid = 1'b0;
    chk(bus_start_n == 1'b1 && bus_cs_n == 1'b0, "R4 cs held in T2", {30'd0, bus_start_n, bus_cs_n}, 32'd2);
    chk(rsp_done == 1'b0, "R2 no done in T2", {31'd0, rsp_done}, 32'd0);
    chk(bus_addr == a, "R9 addr in T2", 32'(bus_addr), 32'(a));
    chk(bus_ack == !al, "R10 ack active in T2", {31'd0, bus_ack}, {31'd0, !al});
    if (w) begin
      chk(bus_we_n == we_exp, "R6 lane enables", {28'd0, bus_we_n}, {28'd0, we_exp});
      chk(bus_rd_n == 1'b1, "R6 no read strobe on write", {31'd0, bus_rd_n}, 32'd1);
      chk(bus_data == wd, "R7 wdata in T2", bus_data, wd);
    end else begin
      chk(bus_rd_n == 1'b0 && bus_we_n == 4'hF, "R8 read strobe only", {27'd0, bus_rd_n, bus_we_n}, 32'h0F);
      chk(bus_rnw == 1'b1, "R4 rnw read in T2", {31'd0, bus_rnw}, 32'd1);
    end
    @(negedge clk);  // done cycle
    chk(rsp_done == 1'b1, "R2 done after T2", {31'd0, rsp_done}, 32'd1);
    chk(bus_cs_n && bus_rd_n && bus_we_n == 4'hF && bus_start_n, "R1 quiet after access",
        {26'd0, bus_cs_n, bus_rd_n, bus_we_n}, 32'h3F);
    chk(bus_ack == al, "R10 ack inactive", {31'd0, bus_ack}, {31'd0, al});
    if (!w) chk(rsp_rdata == rd_pat(a), "R8 full word captured", rsp_rdata, rd_pat(a));
    if (intrude) begin
      @(negedge clk);
      chk(bus_cs_n && bus_start_n, "R11 busy request ignored", {30'd0, bus_cs_n, bus_start_n}, 32'd3);
      chk(rsp_done == 1'b0, "R11 no extra done", {31'd0, rsp_done}, 32'd0);
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
    req_addr = '0; req_wdata = '0; wait_cfg = '0; ack_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && bus_cs_n && bus_rd_n && bus_we_n == 4'hF && bus_start_n,
        "R1 reset state", {26'd0, req_ready, bus_cs_n, bus_rd_n, bus_start_n, bus_rnw, bus_ack},
        32'h3E);
    chk(rsp_done == 1'b0, "R1 no done after reset", {31'd0, rsp_done}, 32'd0);
    for (int wc = 0; wc < 4; wc++)
      for (int sz = 0; sz < 4; sz++)
        for (int lo = 0; lo < 4; lo++)
          for (int w = 0; w < 2; w++)
            access(w[0], sz[1:0], 26'h12340 + AW'(lo) + AW'(wc * 64 + sz * 16),
                   wc, (lo + wc) % 2 == 1, 1'b0);
    access(1'b0, 2'd0, 26'h2ABC1, 2, 1'b0, 1'b1);
    access(1'b1, 2'd1, 26'h0F0F2, 3, 1'b1, 1'b1);
    access(1'b0, 2'd2, 26'h3FFFFFF, 0, 1'b1, 1'b1);
    finish_run();
  end

endmodule